// File: doc/BRIEF.md
# Lane-Splittable Prefix Adder

This block adds two W-bit operands through a single logarithmic-depth parallel prefix carry tree. The same tree can also work as several narrower adders side by side. A two-bit mode input picks one of three arrangements:

- one full-width lane;
- two half-width lanes;
- four quarter-width lanes.

Carries move freely inside a lane and never cross into the lane above it. Each lane reports its own carry-out.

Lanes are isolated inside the bit cells, not by gating the carry chain. At every active lane boundary bit, that bit's carry-propagate (not-kill) term is forced low. This costs no extra depth, because a group that is marked "generate and not propagate" is a state the combine operator never has to resolve. Any tree cell that spans a boundary therefore passes nothing across it. The carry into the boundary bit is masked before the sum XOR. The unmasked group generate at the same point is kept as the lower lane's carry-out. The sum and the carry-outs are registered once at the block's edge.

Top module: `padd_top`

## Requirements
- R1: With mode 00 the block forms one W-bit lane: sum equals (a + b) mod 2^W and cout[0] equals bit W of a + b.
- R2: With mode 01 the block forms two lanes of W/2 bits. Lane j occupies sum bits [j*W/2 +: W/2], is the sum of the matching slices of a and b, and its carry-out appears on cout[j].
- R3: With mode 10 the block forms four lanes of W/4 bits. Lane j occupies sum bits [j*W/4 +: W/4] and its carry-out appears on cout[j].
- R4: Mode 11 behaves exactly as mode 10.
- R5: No carry crosses an active lane boundary. A lane whose slices add to 2^(lane width) or more yields all zeros plus a carry-out, and the lane above it is unchanged.
- R6: cout bits of lanes that the current mode does not use are 0. These are bits 3..1 in mode 00 and bits 3..2 in mode 01.
- R7: sum and cout are registered. The result for the inputs present at a rising clock edge appears after that edge, and a new operand set may be applied every cycle.
- R8: A synchronous active-high reset clears sum and cout to 0.
- R9: Boundaries that the current mode does not use pass carries normally. In mode 00, a carry out of bit W/4-1 or W/2-1 reaches the bits above it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a | input | W | First operand |
| b | input | W | Second operand |
| mode | input | 2 | Lane split: 00 one lane, 01 two lanes, 10 or 11 four lanes |
| sum | output | W | Packed lane sums, registered |
| cout | output | 4 | Per-lane carry-out, lane j on bit j, registered |

## Verification
Every result is due exactly one rising edge after its operands and mode are applied. The prefix tree and lane masking settle within that cycle, and one output register follows.

The bench applies each operand set on a falling edge and, at the same moment, pushes the expected sum and carry vector into a queue. A monitor pops one entry per rising edge, shortly after that edge, so results are matched to stimulus in order, including when operand sets are applied back to back.

Boundary cases (all-ones lanes plus one, and carries across boundaries that are not in use) are compared against a bit-serial reference model that restarts its carry at each lane start.

// File: rtl/padd_pkg.sv
package padd_pkg;

    typedef enum logic [1:0] {
        MODE_FULL    = 2'b00,
        MODE_HALF    = 2'b01,
        MODE_QUARTER = 2'b10,
        MODE_RSVD    = 2'b11
    } padd_mode_e;

    // generate / not-kill pair for a bit or a group of bits
    typedef struct packed {
        logic g;
        logic nk;
    } gk_t;

    // prefix operator: hi spans the upper bits, lo the bits just below
    function automatic gk_t gk_merge(input gk_t hi, input gk_t lo);
        gk_t r;
        r.g  = hi.g | (hi.nk & lo.g);
        r.nk = hi.nk & lo.nk;
        return r;
    endfunction

    function automatic logic is_quarter(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/padd_bitcells.sv
module padd_bitcells
    import padd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [1:0]    mode,
    output gk_t  [W-1:0]  gk,
    output logic [W-1:0]  prop,
    output logic [W-1:0]  bnd
);
    localparam int Q = W / 4;
    localparam int H = W / 2;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == H) begin : g_mid
            assign bnd[i] = (mode != MODE_FULL);
        end else if (i == Q || i == 3 * Q) begin : g_qtr
            assign bnd[i] = is_quarter(mode);
        end else begin : g_none
            assign bnd[i] = 1'b0;
        end
        assign gk[i].g  = a[i] & b[i];
        // OR-AND form: not-kill is held low at an active boundary
        assign gk[i].nk = (a[i] | b[i]) & ~bnd[i];
        assign prop[i]  = a[i] ^ b[i];
    end
endmodule

// File: rtl/padd_tree.sv
module padd_tree
    import padd_pkg::*;
#(
    parameter int W = 32
) (
    input  gk_t  [W-1:0] leaf,
    output logic [W-1:0] grp_g
);
    localparam int L = $clog2(W);

    gk_t [W-1:0] lvl [0:L];

    assign lvl[0] = leaf;

    for (genvar l = 0; l < L; l++) begin : g_lvl
        localparam int D = 1 << l;
        for (genvar i = 0; i < W; i++) begin : g_cell
            if (i >= D) begin : g_op
                assign lvl[l+1][i] = gk_merge(lvl[l][i], lvl[l][i-D]);
            end else begin : g_pass
                assign lvl[l+1][i] = lvl[l][i];
            end
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_out
        assign grp_g[i] = lvl[L][i].g;
    end
endmodule

// File: rtl/padd_post.sv
module padd_post
    import padd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] grp_g,
    input  logic [W-1:0] bnd,
    input  logic [1:0]   mode,
    output logic [W-1:0] sum_d,
    output logic [3:0]   cout_d
);
    localparam int Q = W / 4;
    localparam int H = W / 2;

    logic [W-1:0] cin;

    for (genvar i = 0; i < W; i++) begin : g_cin
        if (i == 0) begin : g_lsb
            assign cin[i] = 1'b0;
        end else begin : g_up
            assign cin[i] = grp_g[i-1] & ~bnd[i];
        end
    end

    assign sum_d = prop ^ cin;

    always_comb begin
        unique case (mode)
            MODE_FULL: cout_d = {3'b000, grp_g[W-1]};
            MODE_HALF: cout_d = {2'b00, grp_g[W-1], grp_g[H-1]};
            default:   cout_d = {grp_g[W-1], grp_g[3*Q-1], grp_g[H-1], grp_g[Q-1]};
        endcase
    end
endmodule

// File: rtl/padd_top.sv
module padd_top
    import padd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   mode,
    output logic [W-1:0] sum,
    output logic [3:0]   cout
);
    localparam int Q = W / 4;
    localparam int H = W / 2;

    gk_t  [W-1:0] gk;
    logic [W-1:0] prop, bnd, grp_g, sum_d;
    logic [3:0]   cout_d;

    padd_bitcells #(.W(W)) u_cells (
        .a(a), .b(b), .mode(mode), .gk(gk), .prop(prop), .bnd(bnd)
    );

    padd_tree #(.W(W)) u_tree (
        .leaf(gk), .grp_g(grp_g)
    );

    padd_post #(.W(W)) u_post (
        .prop(prop), .grp_g(grp_g), .bnd(bnd), .mode(mode),
        .sum_d(sum_d), .cout_d(cout_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum  <= '0;
            cout <= '0;
        end else begin
            sum  <= sum_d;
            cout <= cout_d;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (sum == '0 && cout == 4'b0000)); // R8

    AST_FULL_ADD: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FULL) |=>
        ({cout[0], sum} == $past({1'b0, a}) + $past({1'b0, b}))); // R1

    AST_FULL_UNUSED: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FULL) |=> (cout[3:1] == 3'b000)); // R6

    AST_HALF_UNUSED: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HALF) |=> (cout[3:2] == 2'b00)); // R6

    for (genvar j = 0; j < 2; j++) begin : g_chk_half
        AST_HALF_LANE: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_HALF) |=>
            ({cout[j], sum[j*H +: H]} ==
             $past({1'b0, a[j*H +: H]}) + $past({1'b0, b[j*H +: H]}))); // R2
    end

    for (genvar j = 0; j < 4; j++) begin : g_chk_qtr
        AST_QUARTER_LANE: assert property (@(posedge clk) disable iff (rst)
            mode[1] |=>
            ({cout[j], sum[j*Q +: Q]} ==
             $past({1'b0, a[j*Q +: Q]}) + $past({1'b0, b[j*Q +: Q]}))); // R3
    end
endmodule

// File: tb/padd_top_test.sv
module padd_top_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0, b = '0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] sum;
    logic [3:0]   cout;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [W+3:0] exp;
        string        tag;
    } item_t;

    item_t sbq[$];

    always #2 clk = ~clk;   // 250 MHz

    padd_top #(.W(W)) uut (
        .clk(clk), .rst(rst), .a(a), .b(b), .mode(mode), .sum(sum), .cout(cout)
    );

    // bit-serial reference: carry restarts at every lane start
    function automatic logic [W+3:0] ref_add(input logic [W-1:0] x, y,
                                             input logic [1:0] m);
        int lanes, lw;
        logic c;
        logic [W-1:0] s;
        logic [3:0] co;
        lanes = (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
        lw = W / lanes;
        s = '0;
        co = 4'b0000;
        c = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i % lw == 0) c = 1'b0;
            s[i] = x[i] ^ y[i] ^ c;
            c = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
            if (i % lw == lw - 1) co[i / lw] = c;
        end
        return {co, s};
    endfunction

    task automatic drive(input logic [W-1:0] x, y, input logic [1:0] m,
                         input string tag);
        item_t it;
        @(negedge clk);
        a = x;
        b = y;
        mode = m;
        it.exp = ref_add(x, y, m);
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // monitor: one result per rising edge, checked just after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                checks++;
                if ({cout, sum} !== it.exp) begin
                    failures++;
                    $display("FAIL %s: got cout=%b sum=%h expected cout=%b sum=%h",
                             it.tag, cout, sum, it.exp[W+3:W], it.exp[W-1:0]);
                end
            end
        end
    end

    initial begin
        #40000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        a = 32'hFFFF_FFFF;
        b = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        checks++;   // R8 reset clears outputs
        if (sum !== '0 || cout !== 4'b0000) begin
            failures++;
            $display("FAIL R8: got cout=%b sum=%h expected cout=0000 sum=00000000",
                     cout, sum);
        end
        @(negedge clk);
        rst = 1'b0;

        // R1 full-width lane
        drive(32'hFFFF_FFFF, 32'h0000_0001, 2'b00, "R1 wrap");
        drive(32'h1234_5678, 32'h8765_4321, 2'b00, "R1 plain");
        drive(32'h8000_0000, 32'h8000_0000, 2'b00, "R1 msb carry");
        // R9 unused boundaries pass carries
        drive(32'h0000_00FF, 32'h0000_0001, 2'b00, "R9 quarter edge");
        drive(32'h0000_FFFF, 32'h0000_0001, 2'b00, "R9 half edge");
        // R2 two lanes
        drive(32'h0000_FFFF, 32'h0000_0001, 2'b01, "R2 low lane wrap");
        drive(32'hFFFF_FFFF, 32'h0001_0001, 2'b01, "R2 both wrap");
        drive(32'hABCD_1234, 32'h1111_F00F, 2'b01, "R2 plain");
        // R6 unused carry-outs
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b01, "R6 half unused");
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, "R6 full unused");
        // R3 four lanes
        drive(32'h80FF_7F01, 32'h8001_01FF, 2'b10, "R3 mixed");
        drive(32'h1020_3040, 32'h0102_0304, 2'b10, "R3 plain");
        // R5 all-ones lanes plus one, no leakage
        drive(32'hFFFF_FFFF, 32'h0101_0101, 2'b10, "R5 quarter all");
        drive(32'h00FF_00FF, 32'h0001_0001, 2'b10, "R5 quarter alt");
        drive(32'h0000_FFFF, 32'h0000_0001, 2'b01, "R5 half");
        // R4 reserved code behaves as four lanes
        drive(32'hFFFF_FFFF, 32'h0101_0101, 2'b11, "R4 all ones");
        drive(32'h80FF_7F01, 32'h8001_01FF, 2'b11, "R4 mixed");
        // R7 back-to-back across modes, every cycle
        for (int n = 0; n < 200; n++) begin
            logic [W-1:0] x, y;
            x = $urandom();
            y = (n % 5 == 0) ? ~x : $urandom();
            drive(x, y, 2'(n % 4), "R7 stream");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule